// File: doc/BRIEF.md
# SMBus Slave Packet Error Code Gate

This block sits inside an SMBus slave, between the byte receiver that shifts bits off the wire and the unit that issues commands onto the chip's internal bus. Each received byte arrives as a one-cycle strobe. The block runs a CRC-8 over the address, command and data bytes of the transaction. When the command asks for error checking, the block compares the byte that follows the data against that CRC. It decides, byte by byte, whether the bit engine should acknowledge. The command is held in a local buffer. It is presented to the internal issuer only once every byte has been accepted and, where checking is on, the trailing check byte has matched. A mismatch forces a NACK on the check byte itself, and the buffered command is thrown away.

Commands can be chained into a sequence that opens with a begin flag and closes with an end flag. The block remembers whether the sequence runs with checking on or off, and it rejects a command that changes that mode partway through. After a check failure or a mode change, it accepts nothing but a fresh begin command. When the internal issuer finishes, the block reports the outcome. A failure on the internal side (a parity error on the address, or an abort seen by the master or the target) completes as a NACK with the end indication set, so that the SMBus master repeats the whole transaction.

Top module: `smbus_pec_gate`

## Requirements
- R1: The check value is a CRC-8 with polynomial x^8+x^2+x+1 (0x07) and a start value of 0x00. It is processed MSB first, one byte per strobe, over the address byte, the command byte and the data bytes of the current transaction, and it restarts at every START. When checking is enabled, the byte after the last data byte is compared with it. A match acknowledges that byte (ack_n_o = 0) and raises pec_ok_o for one cycle.
- R2: A check byte that does not match is NACKed (ack_n_o = 1) and raises pec_err_o for one cycle. The command is never presented on cmd_valid_o. Every further byte is NACKed until the next START.
- R3: With checking disabled, the command is presented right after its last data byte, or right after the command byte when the length is zero. No check byte is expected, and neither pec_ok_o nor pec_err_o is raised.
- R4: The command byte is decoded as follows: bit 7 is begin, bit 6 is end, bit 5 enables checking, bits 3:0 give the data length. A length above MAX_LEN is NACKed on the command byte, and the transaction is dropped.
- R5: cmd_valid_o stays high, with cmd_addr_o, cmd_code_o, cmd_len_o and cmd_data_o stable, until cmd_ready_i is seen high at a clock edge. Data byte i appears in cmd_data_o[8*i+7:8*i]. Bytes that arrive while a command is pending or executing are NACKed.
- R6: A command without the begin flag that arrives while a sequence is open, and whose checking flag differs from the sequence's mode, is NACKed on the command byte. It puts the sequence into the error state.
- R7: In the error state, every command without the begin flag is NACKed. A command with the begin flag is accepted, clears the error and sets the sequence mode from its own checking flag.
- R8: When int_done_i is seen high while a command is executing, resp_valid_o pulses for one cycle. If int_err_i is high, resp_nack_o = 1 and resp_end_o = 1. Otherwise resp_nack_o = 0 and resp_end_o copies the command's end flag. Either an end flag or an internal error closes the sequence, so a later command without begin sets a new mode.
- R9: After reset, ack_n_o = 1, while cmd_valid_o, pec_ok_o, pec_err_o and resp_valid_o are 0, and no sequence is open.
- R10: ack_n_o changes only in the cycle after a byte strobe and otherwise holds its value. The address byte and the data bytes of an accepted command are ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | START condition seen on the bus |
| byte_valid_i | input | 1 | One-cycle strobe for a received byte |
| byte_i | input | 8 | Received byte |
| ack_n_o | output | 1 | Acknowledge decision for the last byte (0 = ACK, 1 = NACK) |
| pec_ok_o | output | 1 | Pulse: check byte matched |
| pec_err_o | output | 1 | Pulse: check byte mismatched |
| cmd_valid_o | output | 1 | Buffered command offered to the internal issuer |
| cmd_ready_i | input | 1 | Issuer takes the command |
| cmd_addr_o | output | 8 | Address byte of the command |
| cmd_code_o | output | 8 | Command byte (flags and length) |
| cmd_len_o | output | 4 | Data length |
| cmd_data_o | output | 8*MAX_LEN | Data bytes, byte 0 in the low bits |
| int_done_i | input | 1 | Internal command finished |
| int_err_i | input | 1 | Internal command failed |
| resp_valid_o | output | 1 | Pulse: completion report |
| resp_nack_o | output | 1 | Completion is a NACK |
| resp_end_o | output | 1 | Completion carries the end indication |

## Verification
The bound checker watches several properties on every cycle. The two check pulses must never fire together, and each must match the acknowledge polarity. A check failure must never sit alongside an offered command. The offered command must stay stable while it waits, and an internal-error completion must carry the end indication. It also checks that ack_n_o and the pulses move only after a byte strobe. Some behaviours can only be shown by the bench's scenarios: the CRC value itself, byte placement in the data field, the sequence rules (a mode change, recovery through a begin command, and the sequence closing on end), and the rejection of an oversized length. Each of these needs a specific order of transactions and a reference value computed outside the design.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;

    localparam int        CMD_LEN_W = 4;
    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_PEC,
        ST_DROP,
        ST_ISSUE,
        ST_WAIT
    } gate_state_e;

    typedef struct packed {
        logic                 begin_f;
        logic                 end_f;
        logic                 pec_f;
        logic [CMD_LEN_W-1:0] len;
    } cmd_fields_t;

    typedef struct packed {
        gate_state_e          state;
        logic [CMD_LEN_W-1:0] cnt;
        logic [7:0]           addr;
        logic [7:0]           code;
        logic                 ack_n;
        logic                 pec_ok;
        logic                 pec_err;
        logic                 cmd_valid;
        logic                 resp_valid;
        logic                 resp_nack;
        logic                 resp_end;
    } gate_regs_t;

    // Split a command byte into its flag and length fields.
    function automatic cmd_fields_t decode_cmd(input logic [7:0] b);
        cmd_fields_t f;
        f.begin_f = b[7];
        f.end_f   = b[6];
        f.pec_f   = b[5];
        f.len     = b[3:0];
        return f;
    endfunction

    // One byte of CRC-8 (poly 0x07), MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] b);
        logic [7:0] c;
        c = crc_in ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/smbus_pec_crc8.sv
module smbus_pec_crc8
    import smbus_pec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       upd_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o
);

    typedef struct packed {
        logic [7:0] crc;
    } crc_regs_t;

    crc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.crc = 8'h00;
        end else if (upd_i) begin
            r_d.crc = crc8_step(r_q.crc, data_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign crc_o = r_q.crc;

endmodule

// File: rtl/smbus_pec_cmd_buf.sv
module smbus_pec_cmd_buf #(
    parameter int MAX_LEN = 8,
    parameter int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 wr_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [7:0]           data_i,
    output logic [MAX_LEN*8-1:0] data_o
);

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
        logic [7:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_i) begin
                slot_d = 8'h00;
            end else if (wr_i && (idx_i == IDX_W'(g))) begin
                slot_d = data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= 8'h00;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign data_o[g*8 +: 8] = slot_q;
    end

endmodule

// File: rtl/smbus_pec_seq_track.sv
module smbus_pec_seq_track (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic begin_i,
    input  logic pec_en_i,
    input  logic fail_i,
    input  logic close_i,
    output logic open_o,
    output logic pec_o,
    output logic err_o
);

    typedef struct packed {
        logic open;
        logic pec;
        logic err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (accept_i && (begin_i || !r_q.open)) begin
            r_d.open = 1'b1;
            r_d.pec  = pec_en_i;
            r_d.err  = 1'b0;
        end
        if (fail_i) begin
            r_d.err = 1'b1;
        end
        if (close_i) begin
            r_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign open_o = r_q.open;
    assign pec_o  = r_q.pec;
    assign err_o  = r_q.err;

endmodule

// File: rtl/smbus_pec_gate.sv
module smbus_pec_gate
    import smbus_pec_pkg::*;
#(
    parameter int MAX_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 byte_valid_i,
    input  logic [7:0]           byte_i,
    output logic                 ack_n_o,
    output logic                 pec_ok_o,
    output logic                 pec_err_o,
    output logic                 cmd_valid_o,
    input  logic                 cmd_ready_i,
    output logic [7:0]           cmd_addr_o,
    output logic [7:0]           cmd_code_o,
    output logic [3:0]           cmd_len_o,
    output logic [MAX_LEN*8-1:0] cmd_data_o,
    input  logic                 int_done_i,
    input  logic                 int_err_i,
    output logic                 resp_valid_o,
    output logic                 resp_nack_o,
    output logic                 resp_end_o
);

    localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    gate_regs_t r_d, r_q;

    logic        crc_clr, crc_upd;
    logic [7:0]  crc_val;
    logic        buf_clr, buf_wr;
    logic        seq_accept, seq_fail, seq_close;
    logic        seq_open, seq_pec, seq_err;
    cmd_fields_t fields;
    logic [CMD_LEN_W-1:0] next_cnt;

    smbus_pec_crc8 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (crc_clr),
        .upd_i  (crc_upd),
        .data_i (byte_i),
        .crc_o  (crc_val)
    );

    smbus_pec_cmd_buf #(
        .MAX_LEN (MAX_LEN),
        .IDX_W   (IDX_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (buf_clr),
        .wr_i   (buf_wr),
        .idx_i  (r_q.cnt[IDX_W-1:0]),
        .data_i (byte_i),
        .data_o (cmd_data_o)
    );

    smbus_pec_seq_track u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (seq_accept),
        .begin_i  (fields.begin_f),
        .pec_en_i (fields.pec_f),
        .fail_i   (seq_fail),
        .close_i  (seq_close),
        .open_o   (seq_open),
        .pec_o    (seq_pec),
        .err_o    (seq_err)
    );

    assign fields   = decode_cmd(byte_i);
    assign next_cnt = r_q.cnt + 4'd1;

    always_comb begin
        r_d            = r_q;
        r_d.pec_ok     = 1'b0;
        r_d.pec_err    = 1'b0;
        r_d.resp_valid = 1'b0;
        crc_clr        = 1'b0;
        crc_upd        = 1'b0;
        buf_clr        = 1'b0;
        buf_wr         = 1'b0;
        seq_accept     = 1'b0;
        seq_fail       = 1'b0;
        seq_close      = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_ADDR;
                    crc_clr   = 1'b1;
                    buf_clr   = 1'b1;
                end else if (byte_valid_i) begin
                    r_d.ack_n = 1'b1;
                end
            end

            ST_ISSUE: begin
                if (byte_valid_i) begin
                    r_d.ack_n = 1'b1;
                end
                if (cmd_ready_i) begin
                    r_d.state = ST_WAIT;
                end
            end

            ST_WAIT: begin
                if (byte_valid_i) begin
                    r_d.ack_n = 1'b1;
                end
                if (int_done_i) begin
                    r_d.state      = ST_IDLE;
                    r_d.resp_valid = 1'b1;
                    r_d.resp_nack  = int_err_i;
                    r_d.resp_end   = int_err_i | r_q.code[6];
                    seq_close      = int_err_i | r_q.code[6];
                end
            end

            default: begin
                if (start_i) begin
                    r_d.state = ST_ADDR;
                    crc_clr   = 1'b1;
                    buf_clr   = 1'b1;
                end else if (byte_valid_i) begin
                    unique case (r_q.state)
                        ST_ADDR: begin
                            r_d.ack_n = 1'b0;
                            r_d.addr  = byte_i;
                            crc_upd   = 1'b1;
                            r_d.state = ST_CMD;
                        end

                        ST_CMD: begin
                            if (int'(fields.len) > MAX_LEN) begin
                                r_d.ack_n = 1'b1;
                                r_d.state = ST_DROP;
                            end else if (seq_err && !fields.begin_f) begin
                                r_d.ack_n = 1'b1;
                                r_d.state = ST_DROP;
                            end else if (!fields.begin_f && seq_open &&
                                         (fields.pec_f != seq_pec)) begin
                                r_d.ack_n = 1'b1;
                                r_d.state = ST_DROP;
                                seq_fail  = 1'b1;
                            end else begin
                                r_d.ack_n  = 1'b0;
                                r_d.code   = byte_i;
                                r_d.cnt    = '0;
                                crc_upd    = 1'b1;
                                seq_accept = 1'b1;
                                if (fields.len != '0) begin
                                    r_d.state = ST_DATA;
                                end else if (fields.pec_f) begin
                                    r_d.state = ST_PEC;
                                end else begin
                                    r_d.state = ST_ISSUE;
                                end
                            end
                        end

                        ST_DATA: begin
                            r_d.ack_n = 1'b0;
                            buf_wr    = 1'b1;
                            crc_upd   = 1'b1;
                            r_d.cnt   = next_cnt;
                            if (next_cnt == r_q.code[3:0]) begin
                                r_d.state = r_q.code[5] ? ST_PEC : ST_ISSUE;
                            end
                        end

                        ST_PEC: begin
                            if (byte_i == crc_val) begin
                                r_d.ack_n  = 1'b0;
                                r_d.pec_ok = 1'b1;
                                r_d.state  = ST_ISSUE;
                            end else begin
                                r_d.ack_n   = 1'b1;
                                r_d.pec_err = 1'b1;
                                r_d.state   = ST_DROP;
                                seq_fail    = 1'b1;
                            end
                        end

                        default: begin
                            r_d.ack_n = 1'b1;
                        end
                    endcase
                end
            end
        endcase

        r_d.cmd_valid = (r_d.state == ST_ISSUE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.ack_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_n_o      = r_q.ack_n;
    assign pec_ok_o     = r_q.pec_ok;
    assign pec_err_o    = r_q.pec_err;
    assign cmd_valid_o  = r_q.cmd_valid;
    assign cmd_addr_o   = r_q.addr;
    assign cmd_code_o   = r_q.code;
    assign cmd_len_o    = r_q.code[3:0];
    assign resp_valid_o = r_q.resp_valid;
    assign resp_nack_o  = r_q.resp_nack;
    assign resp_end_o   = r_q.resp_end;

endmodule

// File: rtl/smbus_pec_gate_chk.sv
module smbus_pec_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid_i,
    input logic       ack_n_o,
    input logic       pec_ok_o,
    input logic       pec_err_o,
    input logic       cmd_valid_o,
    input logic       cmd_ready_i,
    input logic [7:0] cmd_addr_o,
    input logic [7:0] cmd_code_o,
    input logic       resp_valid_o,
    input logic       resp_nack_o,
    input logic       resp_end_o
);

    assert_pec_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(pec_ok_o && pec_err_o));

    assert_pec_ok_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pec_ok_o |-> !ack_n_o);

    assert_pec_err_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pec_err_o |-> ack_n_o);

    assert_pec_err_noissue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pec_err_o |=> !cmd_valid_o);

    assert_pulse_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_ok_o || pec_err_o) |-> $past(byte_valid_i));

    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_addr_o)));

    assert_resp_err_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_nack_o) |-> resp_end_o);

    assert_ack_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_valid_i) |-> (ack_n_o == $past(ack_n_o)));

endmodule

bind smbus_pec_gate smbus_pec_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid_i (byte_valid_i),
    .ack_n_o      (ack_n_o),
    .pec_ok_o     (pec_ok_o),
    .pec_err_o    (pec_err_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_code_o   (cmd_code_o),
    .resp_valid_o (resp_valid_o),
    .resp_nack_o  (resp_nack_o),
    .resp_end_o   (resp_end_o)
);

// File: tb/sim_smbus_pec_gate.sv
`timescale 1ns/1ps
module sim_smbus_pec_gate;

    localparam int MAX_LEN = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic                 byte_valid_i = 1'b0;
    logic [7:0]           byte_i = 8'h00;
    logic                 ack_n_o, pec_ok_o, pec_err_o, cmd_valid_o;
    logic                 cmd_ready_i = 1'b0;
    logic [7:0]           cmd_addr_o, cmd_code_o;
    logic [3:0]           cmd_len_o;
    logic [MAX_LEN*8-1:0] cmd_data_o;
    logic                 int_done_i = 1'b0;
    logic                 int_err_i = 1'b0;
    logic                 resp_valid_o, resp_nack_o, resp_end_o;

    smbus_pec_gate #(.MAX_LEN(MAX_LEN)) u0 (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic  ackn;
        logic  ok;
        logic  err;
        string req;
    } exp_t;

    exp_t       expq[$];
    int         vectors = 0;
    int         misses  = 0;
    int         cycles  = 0;
    logic       sampled_v = 1'b0;
    logic [7:0] m_crc;
    logic [7:0] dat_g [16];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x;
        x = c ^ b;
        for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    // Monitor: compare the acknowledge result one cycle after each byte strobe.
    always @(posedge clk) sampled_v <= byte_valid_i;

    always @(negedge clk) begin
        if (sampled_v) begin
            if (expq.size() == 0) begin
                chk(0, "R10 unexpected byte result", 0, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(ack_n_o == e.ackn, {e.req, " ack_n"}, ack_n_o, e.ackn);
                chk(pec_ok_o == e.ok,  {e.req, " pec_ok"}, pec_ok_o, e.ok);
                chk(pec_err_o == e.err, {e.req, " pec_err"}, pec_err_o, e.err);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            misses++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        m_crc = 8'h00;
    endtask

    task automatic send(input logic [7:0] b, input logic ackn, input logic ok, input logic err, input string req);
        exp_t e;
        e.ackn = ackn; e.ok = ok; e.err = err; e.req = req;
        @(negedge clk);
        expq.push_back(e);
        byte_valid_i = 1'b1;
        byte_i = b;
        m_crc = ref_crc(m_crc, b);
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    // One transaction: address, command, data, optional check byte.
    task automatic txn(input logic [7:0] addr, input logic [7:0] code, input logic cmd_nack,
                       input logic pec_bad, input string req);
        logic [7:0] p;
        pulse_start();
        send(addr, 1'b0, 1'b0, 1'b0, req);
        send(code, cmd_nack, 1'b0, 1'b0, req);
        if (!cmd_nack) begin
            for (int i = 0; i < int'(code[3:0]); i++) send(dat_g[i], 1'b0, 1'b0, 1'b0, req);
            if (code[5]) begin
                p = pec_bad ? (m_crc ^ 8'h5A) : m_crc;
                send(p, pec_bad, !pec_bad, pec_bad, req);
            end
        end
    endtask

    task automatic expect_cmd(input logic [7:0] addr, input logic [7:0] code, input bit poke, input string req);
        logic [63:0] exp_d, mask;
        exp_d = '0; mask = '0;
        for (int i = 0; i < int'(code[3:0]); i++) begin
            exp_d[i*8 +: 8] = dat_g[i];
            mask[i*8 +: 8]  = 8'hFF;
        end
        chk(cmd_valid_o == 1'b1, {req, " cmd_valid"}, cmd_valid_o, 1);
        chk(cmd_addr_o == addr, {req, " addr"}, cmd_addr_o, addr);
        chk(cmd_code_o == code, {req, " code"}, cmd_code_o, code);
        chk(cmd_len_o == code[3:0], {req, " len"}, cmd_len_o, code[3:0]);
        chk((cmd_data_o & mask) == exp_d, {req, " data"}, cmd_data_o & mask, exp_d);
        if (poke) send(8'h55, 1'b1, 1'b0, 1'b0, "R5 byte while pending");
        repeat (2) @(negedge clk);
        chk(cmd_valid_o && cmd_code_o == code, "R5 hold while not ready", cmd_valid_o, 1);
        cmd_ready_i = 1'b1;
        @(negedge clk);
        cmd_ready_i = 1'b0;
        chk(cmd_valid_o == 1'b0, "R5 drop after ready", cmd_valid_o, 0);
    endtask

    task automatic complete(input logic err, input logic exp_end, input string req);
        @(negedge clk);
        int_done_i = 1'b1;
        int_err_i = err;
        @(negedge clk);
        int_done_i = 1'b0;
        int_err_i = 1'b0;
        chk(resp_valid_o == 1'b1, {req, " resp_valid"}, resp_valid_o, 1);
        chk(resp_nack_o == err, {req, " resp_nack"}, resp_nack_o, err);
        chk(resp_end_o == exp_end, {req, " resp_end"}, resp_end_o, exp_end);
        @(negedge clk);
        chk(resp_valid_o == 1'b0, {req, " resp pulse"}, resp_valid_o, 0);
    endtask

    initial begin
        m_crc = 8'h00;
        for (int i = 0; i < 16; i++) dat_g[i] = 8'h30 + 8'(i * 17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(ack_n_o == 1'b1, "R9 ack_n", ack_n_o, 1);
        chk(cmd_valid_o == 1'b0, "R9 cmd_valid", cmd_valid_o, 0);
        chk(!pec_ok_o && !pec_err_o, "R9 pulses", {pec_ok_o, pec_err_o}, 0);
        chk(resp_valid_o == 1'b0, "R9 resp_valid", resp_valid_o, 0);

        // R1: checked command, begin+end, three data bytes; R5 pending byte; R8 clean finish
        txn(8'hA6, 8'hE3, 1'b0, 1'b0, "R1 good pec");
        expect_cmd(8'hA6, 8'hE3, 1'b1, "R1");
        complete(1'b0, 1'b1, "R8 ok end");

        // R3: unchecked command, two data bytes; R8 internal error completion
        dat_g[0] = 8'hFF; dat_g[1] = 8'h01;
        txn(8'h42, 8'hC2, 1'b0, 1'b0, "R3 no pec");
        expect_cmd(8'h42, 8'hC2, 1'b0, "R3");
        complete(1'b1, 1'b1, "R8 internal error");

        // R4: length above MAX_LEN is refused
        txn(8'h42, 8'hC9, 1'b1, 1'b0, "R4 oversize");
        send(8'h00, 1'b1, 1'b0, 1'b0, "R4 after refuse");
        chk(cmd_valid_o == 1'b0, "R4 no issue", cmd_valid_o, 0);

        // R2: check mismatch in a sequence (begin, no end)
        dat_g[0] = 8'h9C;
        txn(8'h10, 8'hA1, 1'b0, 1'b1, "R2 bad pec");
        chk(cmd_valid_o == 1'b0, "R2 no issue", cmd_valid_o, 0);
        send(8'h77, 1'b1, 1'b0, 1'b0, "R2 byte after mismatch");
        repeat (2) @(negedge clk);
        chk(cmd_valid_o == 1'b0, "R2 still no issue", cmd_valid_o, 0);

        // R7: error state refuses non-begin, then begin recovers (checked, len 0, no end)
        txn(8'h10, 8'h20, 1'b1, 1'b0, "R7 non-begin in error");
        txn(8'h10, 8'hA0, 1'b0, 1'b0, "R7 begin recovers");
        expect_cmd(8'h10, 8'hA0, 1'b0, "R7");
        complete(1'b0, 1'b0, "R8 no end");

        // R6: mode change inside the open checked sequence
        txn(8'h10, 8'h01, 1'b1, 1'b0, "R6 mode change");
        txn(8'h10, 8'h20, 1'b1, 1'b0, "R7 error after mode change");

        // R7: begin unchecked, one byte, end closes sequence
        dat_g[0] = 8'h3C;
        txn(8'h11, 8'hC1, 1'b0, 1'b0, "R7 begin unchecked");
        expect_cmd(8'h11, 8'hC1, 1'b0, "R7 unchecked");
        complete(1'b0, 1'b1, "R8 end closes");

        // R8: sequence closed, so a non-begin checked command starts a new mode
        txn(8'h12, 8'h60, 1'b0, 1'b0, "R8 after close");
        expect_cmd(8'h12, 8'h60, 1'b0, "R8 after close");
        complete(1'b0, 1'b1, "R8 final");

        // R10: ack_n holds with no strobes
        repeat (3) @(negedge clk);
        chk(ack_n_o == 1'b0, "R10 hold", ack_n_o, 0);
        chk(expq.size() == 0, "R10 all results seen", expq.size(), 0);
        finish_up();
    end

endmodule